// File: doc/BRIEF.md
# Dual SPI Sample Receiver Interleaver

The block takes two sample streams from a host over two independent SPI slave lanes. Lane 0 carries I samples (channels A and C) and lane 1 carries Q samples (channels B and D). Each lane builds 16-bit samples from pairs of bytes. A completed sample moves into the system clock domain through a toggle handshake and is stored in that lane's own FIFO.

On the read side, the block always presents the oldest eight samples of each FIFO as one 256-bit word. The two lanes are interleaved one sample at a time. A burst-ready flag tells the consumer when both FIFOs hold enough data for a four-word burst. A single read strobe removes one word's worth of samples from both lanes at once.

Each lane runs a two-state receive machine in its SCK domain:
- `RX_LOW` collects bits 0 to 7 of a sample. After the eighth bit it moves to `RX_HIGH`.
- `RX_HIGH` collects bits 8 to 15. After the sixteenth bit it emits the sample and returns to `RX_LOW`.
- Whenever SS is high, the machine is forced back to `RX_LOW` with its bit counter at zero.

Top module: `dual_spi_interleaver`

## Requirements
- R1: Each lane samples MOSI on the rising SCK edge (idle SCK high, CPOL=1, CPHA=1). Bytes are sent least significant bit first. The first byte of a pair is the low byte of the sample and the second byte is the high byte.
- R2: When SS goes high, the lane's bit count returns to zero and any partial sample is discarded. The next low SS period starts a fresh sample.
- R3: Every completed 16-bit sample is written into its own lane's FIFO in the system clock domain within a few system clock cycles.
- R4: In the output word, 16-bit slot 2j (bits 32j+15 down to 32j) holds the j-th oldest lane 0 sample. Slot 2j+1 holds the j-th oldest lane 1 sample, for j = 0 to 7.
- R5: `burst_rdy` is high exactly when each FIFO holds at least 32 samples (four 128-bit words).
- R6: A cycle with `rd` high removes 8 samples from both FIFOs, but only if both hold at least 8 samples. Otherwise the strobe has no effect.
- R7: `flush[i]` empties lane i's FIFO and clears its overflow flag.
- R8: A sample that arrives when its FIFO already holds 128 samples is dropped. The lane's `ovf_err` bit then stays high until that lane is flushed or the block is reset.
- R9: `pend[i]` is high whenever lane i's FIFO holds at least one unread sample.
- R10: After reset, `burst_rdy`, `ovf_err` and `pend` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 2 | SPI clock per lane, idle high |
| spi_ss_n | input | 2 | Active-low slave select per lane |
| spi_mosi | input | 2 | Serial data per lane |
| flush | input | 2 | Per-lane FIFO clear |
| rd | input | 1 | Read strobe, pops both lanes together |
| out_word | output | 256 | Oldest eight samples of each lane, interleaved |
| burst_rdy | output | 1 | Both FIFOs hold at least four output words |
| ovf_err | output | 2 | Sticky per-lane overflow flag |
| pend | output | 2 | Per-lane unread samples present |

## Verification
A receive machine that is left in the wrong state, or a bit count that survives the rise of SS, shifts bytes or bits within a sample. This shows up as a wrong value in the lowest slots of `out_word` about four system cycles after the last SCK edge of the sample.

Pointer or fill errors in a FIFO show up on the next system cycle. They appear as a wrong `burst_rdy`, a wrong `pend`, or slots that do not advance by eight after a strobe.

A lost overflow flag or a flush that does not act is visible directly on `ovf_err` and `pend` one cycle later.

// File: rtl/spi_ilv_pkg.sv
package spi_ilv_pkg;
    typedef enum logic [0:0] {
        RX_LOW  = 1'b0,
        RX_HIGH = 1'b1
    } rx_phase_e;
endpackage

// File: rtl/spi_lane_rx.sv
module spi_lane_rx
    import spi_ilv_pkg::*;
#(
    parameter int unsigned SMP_W = 16
) (
    input  logic             rst_n,
    input  logic             sck,
    input  logic             ss_n,
    input  logic             mosi,
    output logic [SMP_W-1:0] smp_hold,
    output logic             smp_tog
);
    localparam int unsigned HALF = SMP_W / 2;
    localparam int unsigned CW   = $clog2(HALF);

    logic             clr;
    rx_phase_e        st, st_nx;
    logic [CW-1:0]    bit_cnt;
    logic [SMP_W-1:0] shreg;
    logic             emit;

    assign clr = ss_n | ~rst_n;

    // State register: restarted whenever the slave is deselected
    always_ff @(posedge sck or posedge clr) begin
        if (clr) begin
            st      <= RX_LOW;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            st      <= st_nx;
            bit_cnt <= bit_cnt + 1'b1;
            shreg   <= {mosi, shreg[SMP_W-1:1]};
        end
    end

    // Next state and emit decode
    always_comb begin
        st_nx = st;
        emit  = 1'b0;
        unique case (st)
            RX_LOW:  if (&bit_cnt) st_nx = RX_HIGH;
            RX_HIGH: if (&bit_cnt) begin
                st_nx = RX_LOW;
                emit  = 1'b1;
            end
        endcase
    end

    // Completed sample is held stable for the crossing
    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) begin
            smp_hold <= '0;
            smp_tog  <= 1'b0;
        end else if (emit) begin
            smp_hold <= {mosi, shreg[SMP_W-1:1]};
            smp_tog  <= ~smp_tog;
        end
    end
endmodule

// File: rtl/toggle_sync.sv
module toggle_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic pulse
);
    logic [STAGES:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-1:0], tog_in};
    end

    assign pulse = sr[STAGES] ^ sr[STAGES-1];
endmodule

// File: rtl/lane_fifo.sv
module lane_fifo #(
    parameter int unsigned SMP_W = 16,
    parameter int unsigned DEPTH = 128,
    parameter int unsigned POP_N = 8,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned CNT_W = AW + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   push,
    input  logic [SMP_W-1:0]       wdata,
    input  logic                   pop,
    output logic [POP_N*SMP_W-1:0] head,
    output logic [CNT_W-1:0]       fill,
    output logic                   ovf
);
    localparam int unsigned PW = $clog2(POP_N);

    logic [SMP_W-1:0] mem [DEPTH];
    logic [AW:0]      wptr, rptr;
    logic             full;

    assign fill = wptr - rptr;
    assign full = (fill == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (push && !full && !flush) mem[wptr[AW-1:0]] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            ovf  <= 1'b0;
        end else if (flush) begin
            wptr <= '0;
            rptr <= '0;
            ovf  <= 1'b0;
        end else begin
            if (push) begin
                if (full) ovf  <= 1'b1;
                else      wptr <= wptr + 1'b1;
            end
            if (pop) rptr <= rptr + (AW+1)'(POP_N);
        end
    end

    for (genvar j = 0; j < POP_N; j++) begin : g_head
        assign head[j*SMP_W +: SMP_W] = mem[{rptr[AW-1:PW], PW'(j)}];
    end

    p_fill_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !flush) |=> ovf);
    p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fill == '0) && !ovf);
    p_pop_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush && !push) |=> fill == $past(fill) - CNT_W'(POP_N));
endmodule

// File: rtl/dual_spi_interleaver.sv
module dual_spi_interleaver #(
    parameter int unsigned SMP_W       = 16,
    parameter int unsigned LANE_BITS   = 128,
    parameter int unsigned FIFO_DEPTH  = 128,
    parameter int unsigned BURST_WORDS = 4,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned OUT_W      = 2 * LANE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       spi_sck,
    input  logic [1:0]       spi_ss_n,
    input  logic [1:0]       spi_mosi,
    input  logic [1:0]       flush,
    input  logic             rd,
    output logic [OUT_W-1:0] out_word,
    output logic             burst_rdy,
    output logic [1:0]       ovf_err,
    output logic [1:0]       pend
);
    localparam int unsigned POP_N     = LANE_BITS / SMP_W;
    localparam int unsigned READY_LVL = BURST_WORDS * POP_N;
    localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH) + 1;

    logic [LANE_BITS-1:0] head [2];
    logic [CNT_W-1:0]     fill [2];
    logic [1:0]           push;
    logic [1:0]           has_word;
    logic                 pop_ok;

    for (genvar l = 0; l < 2; l++) begin : g_lane
        logic [SMP_W-1:0] hold;
        logic             tog;

        spi_lane_rx #(.SMP_W(SMP_W)) i_rx (
            .rst_n    (rst_n),
            .sck      (spi_sck[l]),
            .ss_n     (spi_ss_n[l]),
            .mosi     (spi_mosi[l]),
            .smp_hold (hold),
            .smp_tog  (tog)
        );

        toggle_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .tog_in (tog),
            .pulse  (push[l])
        );

        lane_fifo #(.SMP_W(SMP_W), .DEPTH(FIFO_DEPTH), .POP_N(POP_N)) i_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .flush (flush[l]),
            .push  (push[l]),
            .wdata (hold),
            .pop   (pop_ok),
            .head  (head[l]),
            .fill  (fill[l]),
            .ovf   (ovf_err[l])
        );

        assign has_word[l] = fill[l] >= CNT_W'(POP_N);
        assign pend[l]     = fill[l] != '0;
    end

    assign pop_ok    = rd && (&has_word);
    assign burst_rdy = (fill[0] >= CNT_W'(READY_LVL)) && (fill[1] >= CNT_W'(READY_LVL));

    for (genvar j = 0; j < POP_N; j++) begin : g_ilv
        assign out_word[(2*j)*SMP_W   +: SMP_W] = head[0][j*SMP_W +: SMP_W];
        assign out_word[(2*j+1)*SMP_W +: SMP_W] = head[1][j*SMP_W +: SMP_W];
    end

    // Ready can only drop through a read or a flush
    p_ready_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_rdy && !rd && flush == 2'b00) |=> burst_rdy);
endmodule

// File: tb/test_dual_spi_interleaver.sv
module test_dual_spi_interleaver;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sck_d  [2];
    logic         ss_d   [2];
    logic         mosi_d [2];
    logic [1:0]   flush = 2'b00;
    logic         rd = 1'b0;
    logic [255:0] out_word;
    logic         burst_rdy;
    logic [1:0]   ovf_err, pend;
    int           n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    dual_spi_interleaver i_dual_spi_interleaver (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sck   ({sck_d[1], sck_d[0]}),
        .spi_ss_n  ({ss_d[1], ss_d[0]}),
        .spi_mosi  ({mosi_d[1], mosi_d[0]}),
        .flush     (flush),
        .rd        (rd),
        .out_word  (out_word),
        .burst_rdy (burst_rdy),
        .ovf_err   (ovf_err),
        .pend      (pend)
    );

    function automatic logic [15:0] smp(int lane, int n);
        logic [7:0] hi = (lane == 1 ? 8'hC3 : 8'h3C) ^ 8'(n);
        logic [7:0] lo = 8'(n * 7 + 1);
        return {hi, lo};
    endfunction

    function automatic logic [15:0] slot(int k);
        return out_word[k*16 +: 16];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (10) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic shift_bits(int lane, logic [15:0] v, int nb);
        for (int b = 0; b < nb; b++) begin
            sck_d[lane]  = 1'b0;
            mosi_d[lane] = v[b];
            #20;
            sck_d[lane]  = 1'b1;
            #20;
        end
    endtask

    task automatic send_words(int lane, int first, int cnt);
        ss_d[lane] = 1'b0;
        #20;
        for (int i = 0; i < cnt; i++) shift_bits(lane, smp(lane, first + i), 16);
        #20;
        ss_d[lane] = 1'b1;
        #40;
    endtask

    task automatic pulse_rd();
        @(negedge clk) rd = 1'b1;
        @(negedge clk) rd = 1'b0;
    endtask

    task automatic pulse_flush(logic [1:0] m);
        @(negedge clk) flush = m;
        @(negedge clk) flush = 2'b00;
    endtask

    task automatic t_reset();
        chk("R10 burst_rdy", 32'(burst_rdy), 0);
        chk("R10 ovf_err", 32'(ovf_err), 0);
        chk("R10 pend", 32'(pend), 0);
    endtask

    task automatic t_partial_and_order();
        // five stray bits, then deselect: must be discarded
        ss_d[0] = 1'b0;
        #20;
        shift_bits(0, 16'hFFFF, 5);
        ss_d[0] = 1'b1;
        #40;
        settle();
        chk("R2 no sample from partial frame", 32'(pend), 0);
        ss_d[0] = 1'b0;
        #20;
        shift_bits(0, 16'hB3C5, 16);
        ss_d[0] = 1'b1;
        settle();
        chk("R3 sample stored lane0", 32'(pend), 2'b01);
        chk("R1 byte and bit order", 32'(slot(0)), 32'h0000B3C5);
        pulse_flush(2'b01);
        @(negedge clk);
        chk("R7 flush lane0 empties", 32'(pend), 0);
    endtask

    task automatic t_interleave();
        fork
            send_words(0, 0, 31);
            send_words(1, 0, 31);
        join
        settle();
        chk("R5 not ready at 31/31", 32'(burst_rdy), 0);
        send_words(0, 31, 1);
        settle();
        chk("R5 not ready at 32/31", 32'(burst_rdy), 0);
        send_words(1, 31, 1);
        settle();
        chk("R5 ready at 32/32", 32'(burst_rdy), 1);
        for (int j = 0; j < 8; j++) begin
            chk("R4 even slot lane0", 32'(slot(2*j)), 32'(smp(0, j)));
            chk("R4 odd slot lane1", 32'(slot(2*j+1)), 32'(smp(1, j)));
        end
        pulse_rd();
        @(negedge clk);
        chk("R5 ready drops at 24/24", 32'(burst_rdy), 0);
        chk("R6 pop advances lane0", 32'(slot(0)), 32'(smp(0, 8)));
        chk("R6 pop advances lane1", 32'(slot(1)), 32'(smp(1, 8)));
        pulse_rd();
        pulse_rd();
        pulse_rd();
        @(negedge clk);
        chk("R9 pend clear after draining", 32'(pend), 0);
        send_words(0, 100, 8);
        settle();
        pulse_rd();
        @(negedge clk);
        chk("R6 strobe ignored when lane1 short", 32'(pend), 2'b01);
        chk("R6 lane0 head unchanged", 32'(slot(0)), 32'(smp(0, 100)));
        pulse_flush(2'b11);
        @(negedge clk);
        chk("R7 flush both", 32'(pend), 0);
    endtask

    task automatic t_overflow();
        send_words(1, 0, 129);
        settle();
        chk("R8 overflow flagged lane1 only", 32'(ovf_err), 2'b10);
        chk("R9 pend lane1", 32'(pend), 2'b10);
        chk("R8 head kept oldest", 32'(slot(1)), 32'(smp(1, 0)));
        repeat (20) @(negedge clk);
        chk("R8 flag sticky", 32'(ovf_err), 2'b10);
        pulse_flush(2'b10);
        @(negedge clk);
        chk("R7 flush clears overflow", 32'(ovf_err), 0);
        chk("R7 flush empties lane1", 32'(pend), 0);
    endtask

    initial begin
        for (int l = 0; l < 2; l++) begin
            sck_d[l]  = 1'b1;
            ss_d[l]   = 1'b1;
            mosi_d[l] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_partial_and_order();
        t_interleave();
        t_overflow();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #3ms;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule